// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Selective Flag Update

This block is the arithmetic section of an accumulator-style processor datapath. It is purely combinational. On each evaluation it takes a 3-bit operation code, the accumulator, a second 8-bit operand, a 16-bit register-pair value and the current flag byte. It returns an 8-bit result, a 16-bit pair result and the next flag byte.

The unit covers six 8-bit operations: add, subtract, increment, decrement, bitwise invert and negate. It also covers two 16-bit operations, pair increment and pair decrement. Each operation carries its own write mask over the flag byte. A flag outside the mask leaves the unit exactly as it came in. A flag inside the mask is either computed or forced.

The surrounding decoder chooses the operation and the operands, and it writes `result_out`, `pair_out` and `flags_out` back where they belong. Increment and decrement work on `opnd_in`, so the same operand register receives the result.

Top module: `accalu_top`

## Requirements
- R1: Operation code 3'd0 (add) returns `acc_in + opnd_in` modulo 256. It sets C to the carry out of bit 7, N to 0, and P/V to signed overflow. The flag byte is laid out from bit 7 to bit 0 as S, Z, spare, H, spare, P/V, N, C.
- R2: Operation code 3'd1 (subtract) returns `acc_in - opnd_in` modulo 256. It sets C when `opnd_in > acc_in` (unsigned borrow), N to 1, and P/V to signed overflow of the difference.
- R3: Operation codes 3'd2 (increment) and 3'd3 (decrement) return `opnd_in + 1` and `opnd_in - 1` modulo 256. C is left as it came in. P/V is set only when increment starts from 0x7F or decrement starts from 0x80. N is 0 for increment and 1 for decrement.
- R4: Operation code 3'd5 (negate) returns `0 - acc_in` modulo 256. It sets C when `acc_in` is nonzero, P/V when `acc_in` is 0x80, and N to 1.
- R5: Operation code 3'd4 (invert) returns `~acc_in`. It forces H (bit 4) and N (bit 1) to 1 and leaves the other six flag bits unchanged.
- R6: Operation codes 3'd6 and 3'd7 return `pair_in + 1` and `pair_in - 1` modulo 65536 on `pair_out`, and `flags_out` equals `flags_in` in full.
- R7: For add, subtract, increment, decrement and negate, S is bit 7 of the result and Z is 1 exactly when the 8-bit result is zero.
- R8: For add, subtract, increment, decrement and negate, H is the carry (for add and increment) or the borrow (for subtract, decrement and negate) between bit 3 and bit 4.
- R9: Flag bits 5 and 3 pass through unchanged for every operation. `pair_out` equals `pair_in` for every 8-bit operation.
- R10: For the pair operations 3'd6 and 3'd7, `result_out` equals `acc_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation code |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second operand (subtrahend, addend, or the target of increment/decrement) |
| pair_in | input | 16 | Register-pair value for the 16-bit operations |
| flags_in | input | 8 | Current flag byte |
| result_out | output | 8 | 8-bit result |
| pair_out | output | 16 | 16-bit pair result |
| flags_out | output | 8 | Next flag byte |

## Verification
The bench builds the unit with its default widths: an 8-bit data path and a 16-bit pair path. At that size every 8-bit operation can be swept across all 65,536 pairs of accumulator and operand. Each vector is driven with an all-ones or an all-zeros incoming flag byte, so the preserved bits and the spare bits are seen in both states. The pair operations are swept across a strided set of values that includes both wrap points. The bench also checks three hand-worked cases directly: subtracting 0x68 from 0xF2, inverting 0x8A, and adding 0xA2 to 0x75.

// File: rtl/accalu_pkg.sv
package accalu_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_INC   = 3'd2,
        OP_DEC   = 3'd3,
        OP_INV   = 3'd4,
        OP_NEG   = 3'd5,
        OP_INC16 = 3'd6,
        OP_DEC16 = 3'd7
    } alu_op_e;

    // Flag byte, bit 7 down to bit 0
    typedef struct packed {
        logic s;
        logic z;
        logic sp5;
        logic h;
        logic sp3;
        logic pv;
        logic n;
        logic c;
    } flag_t;

    localparam int FLAG_W = $bits(flag_t);

    // Adder setup for one 8-bit operation
    typedef struct packed {
        logic use_opnd_x;  // x is opnd_in rather than acc_in
        logic zero_x;      // x is forced to zero
        logic [1:0] ysel;  // 0: opnd, 1: ~opnd, 2: zero, 3: ~acc
        logic cin;
        logic borrow;      // invert carry and half carry
        logic dec_const;   // y becomes all ones except bit 0
    } add_cfg_t;

    function automatic flag_t write_mask(alu_op_e op);
        flag_t m;
        m = '0;
        unique case (op)
            OP_ADD, OP_SUB, OP_NEG: begin
                m.s = 1'b1; m.z = 1'b1; m.h = 1'b1;
                m.pv = 1'b1; m.n = 1'b1; m.c = 1'b1;
            end
            OP_INC, OP_DEC: begin
                m.s = 1'b1; m.z = 1'b1; m.h = 1'b1;
                m.pv = 1'b1; m.n = 1'b1;
            end
            OP_INV: begin
                m.h = 1'b1; m.n = 1'b1;
            end
            default: m = '0;
        endcase
        return m;
    endfunction

    function automatic add_cfg_t adder_setup(alu_op_e op);
        add_cfg_t k;
        k = '0;
        unique case (op)
            OP_ADD: k.ysel = 2'd0;
            OP_SUB: begin k.ysel = 2'd1; k.cin = 1'b1; k.borrow = 1'b1; end
            OP_INC: begin k.use_opnd_x = 1'b1; k.ysel = 2'd2; k.cin = 1'b1; end
            OP_DEC: begin
                k.use_opnd_x = 1'b1; k.ysel = 2'd2; k.dec_const = 1'b1;
                k.cin = 1'b1; k.borrow = 1'b1;
            end
            OP_NEG: begin k.zero_x = 1'b1; k.ysel = 2'd3; k.cin = 1'b1; k.borrow = 1'b1; end
            default: k = '0;
        endcase
        return k;
    endfunction

    function automatic logic is_subtractive(alu_op_e op);
        return (op == OP_SUB) || (op == OP_DEC) || (op == OP_NEG) || (op == OP_INV);
    endfunction

endpackage

// File: rtl/accalu_opsel.sv
module accalu_opsel
    import accalu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e            op,
    input  logic [DATA_W-1:0]  acc,
    input  logic [DATA_W-1:0]  opnd,
    output logic [DATA_W-1:0]  x,
    output logic [DATA_W-1:0]  y,
    output logic               cin,
    output logic               borrow
);
    add_cfg_t cfg;
    logic [DATA_W-1:0] y_base;
    localparam logic [DATA_W-1:0] DEC_Y = {{(DATA_W-1){1'b1}}, 1'b0};

    always_comb begin
        cfg = adder_setup(op);
        if (cfg.zero_x)
            x = '0;
        else if (cfg.use_opnd_x)
            x = opnd;
        else
            x = acc;
        unique case (cfg.ysel)
            2'd0: y_base = opnd;
            2'd1: y_base = ~opnd;
            2'd2: y_base = '0;
            default: y_base = ~acc;
        endcase
        y      = cfg.dec_const ? DEC_Y : y_base;
        cin    = cfg.cin;
        borrow = cfg.borrow;
    end
endmodule

// File: rtl/accalu_addcore.sv
module accalu_addcore #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic              cin,
    input  logic              borrow,
    output logic [DATA_W-1:0] sum,
    output logic              cy,
    output logic              hc,
    output logic              ov
);
    localparam int HB = DATA_W / 2;

    logic [DATA_W:0] full;
    logic [HB:0]     low;

    always_comb begin
        full = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
        low  = {1'b0, x[HB-1:0]} + {1'b0, y[HB-1:0]} + {{HB{1'b0}}, cin};
        sum  = full[DATA_W-1:0];
        cy   = full[DATA_W] ^ borrow;
        hc   = low[HB] ^ borrow;
        ov   = (x[DATA_W-1] == y[DATA_W-1]) && (full[DATA_W-1] != x[DATA_W-1]);
    end
endmodule

// File: rtl/accalu_pair.sv
module accalu_pair
    import accalu_pkg::*;
#(
    parameter int PAIR_W = 16
) (
    input  alu_op_e           op,
    input  logic [PAIR_W-1:0] pair_in,
    output logic [PAIR_W-1:0] pair_out
);
    localparam logic [PAIR_W-1:0] ONE = {{(PAIR_W-1){1'b0}}, 1'b1};

    always_comb begin
        unique case (op)
            OP_INC16: pair_out = pair_in + ONE;
            OP_DEC16: pair_out = pair_in - ONE;
            default:  pair_out = pair_in;
        endcase
    end
endmodule

// File: rtl/accalu_flagmerge.sv
module accalu_flagmerge
    import accalu_pkg::*;
(
    input  flag_t old_f,
    input  flag_t new_f,
    input  flag_t mask,
    output flag_t out_f
);
    always_comb begin
        out_f = (new_f & mask) | (old_f & ~mask);
    end
endmodule

// File: rtl/accalu_top.sv
module accalu_top
    import accalu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAIR_W = 16
) (
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic [PAIR_W-1:0] pair_in,
    input  logic [7:0]        flags_in,
    output logic [DATA_W-1:0] result_out,
    output logic [PAIR_W-1:0] pair_out,
    output logic [7:0]        flags_out
);
    alu_op_e           op;
    logic [DATA_W-1:0] ax, ay, sum;
    logic              cin, borrow, cy, hc, ov;
    flag_t             f_old, f_new, f_mask, f_out;

    assign op    = alu_op_e'(op_sel);
    assign f_old = flag_t'(flags_in);

    accalu_opsel #(.DATA_W(DATA_W)) u_opsel (
        .op(op), .acc(acc_in), .opnd(opnd_in),
        .x(ax), .y(ay), .cin(cin), .borrow(borrow)
    );

    accalu_addcore #(.DATA_W(DATA_W)) u_add (
        .x(ax), .y(ay), .cin(cin), .borrow(borrow),
        .sum(sum), .cy(cy), .hc(hc), .ov(ov)
    );

    accalu_pair #(.PAIR_W(PAIR_W)) u_pair (
        .op(op), .pair_in(pair_in), .pair_out(pair_out)
    );

    always_comb begin
        f_mask = write_mask(op);
        f_new  = '0;
        if (op == OP_INV) begin
            f_new.h = 1'b1;
            f_new.n = 1'b1;
        end else begin
            f_new.s  = sum[DATA_W-1];
            f_new.z  = (sum == '0);
            f_new.h  = hc;
            f_new.pv = ov;
            f_new.n  = is_subtractive(op);
            f_new.c  = cy;
        end
        unique case (op)
            OP_INV:           result_out = ~acc_in;
            OP_INC16, OP_DEC16: result_out = acc_in;
            default:          result_out = sum;
        endcase
    end

    accalu_flagmerge u_merge (
        .old_f(f_old), .new_f(f_new), .mask(f_mask), .out_f(f_out)
    );

    assign flags_out = f_out;

    always_comb begin
        if (op == OP_INC16 || op == OP_DEC16)
            AST_PAIR_FLAGS_KEEP: assert (flags_out == flags_in); // R6
        if (op == OP_INV)
            AST_INV_FLAGS: assert (flags_out == (flags_in | 8'h12)); // R5
        if (op == OP_INC || op == OP_DEC)
            AST_INCDEC_CARRY: assert (flags_out[0] == flags_in[0]); // R3
        if (op == OP_NEG)
            AST_NEG_CARRY: assert (flags_out[0] == (acc_in != '0)); // R4
        if (op == OP_ADD || op == OP_SUB || op == OP_INC || op == OP_DEC || op == OP_NEG)
            AST_SIGN_ZERO: assert (flags_out[7] == result_out[DATA_W-1] &&
                                   flags_out[6] == (result_out == '0)); // R7
        AST_SPARE_BITS: assert (flags_out[5] == flags_in[5] && flags_out[3] == flags_in[3]); // R9
    end
endmodule

// File: tb/sim_accalu_top.sv
`timescale 1ns/1ps
module sim_accalu_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [2:0]  op_sel;
    logic [7:0]  acc_in, opnd_in, flags_in, result_out, flags_out;
    logic [15:0] pair_in, pair_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    accalu_top u0 (
        .op_sel(op_sel), .acc_in(acc_in), .opnd_in(opnd_in), .pair_in(pair_in),
        .flags_in(flags_in), .result_out(result_out), .pair_out(pair_out),
        .flags_out(flags_out)
    );

    function automatic int sgn(int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    // Expected model for the 8-bit operations
    task automatic model8(input int op, input int a, input int b, input logic [7:0] fin,
                          output logic [7:0] er, output logic [7:0] ef);
        int s, sv;
        logic c, h, v, n;
        c = fin[0]; h = 0; v = 0; n = 0; s = 0;
        case (op)
            0: begin s = a + b; c = (s > 255); h = ((a % 16) + (b % 16)) > 15;
                     sv = sgn(a) + sgn(b); v = (sv > 127) || (sv < -128); n = 0; end
            1: begin s = a - b; c = (a < b); h = (a % 16) < (b % 16);
                     sv = sgn(a) - sgn(b); v = (sv > 127) || (sv < -128); n = 1; end
            2: begin s = b + 1; h = (b % 16) == 15; v = (b == 127); n = 0; end
            3: begin s = b - 1; h = (b % 16) == 0; v = (b == 128); n = 1; end
            5: begin s = 0 - a; c = (a != 0); h = (a % 16) != 0; v = (a == 128); n = 1; end
            default: s = 0;
        endcase
        if (op == 4) begin
            er = ~a[7:0];
            ef = fin | 8'h12;
        end else begin
            er = s[7:0];
            ef = {er[7], (er == 8'h00), fin[5], h, fin[3], v, n, c};
        end
    endtask

    task automatic check(input string tag, input logic [7:0] er, input logic [7:0] ef,
                         input logic [15:0] ep);
        checks++;
        if (result_out !== er || flags_out !== ef || pair_out !== ep) begin
            failures++;
            $display("FAIL %s op=%0d a=%h b=%h p=%h fin=%h : got r=%h f=%h p=%h exp r=%h f=%h p=%h",
                     tag, op_sel, acc_in, opnd_in, pair_in, flags_in,
                     result_out, flags_out, pair_out, er, ef, ep);
        end
    endtask

    function automatic string tag_of(int op);
        case (op)
            0: return "R1/R7/R8/R9";
            1: return "R2/R7/R8/R9";
            2, 3: return "R3/R7/R8/R9";
            4: return "R5/R9";
            5: return "R4/R7/R8/R9";
            default: return "R6/R10";
        endcase
    endfunction

    task automatic drive(input int op, input int a, input int b, input int p, input logic [7:0] f);
        op_sel = op[2:0]; acc_in = a[7:0]; opnd_in = b[7:0]; pair_in = p[15:0]; flags_in = f;
        #1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] er, ef;
        // Quiet state with all inputs zero: add 0+0
        drive(0, 0, 0, 0, 8'h00);
        check("R1 idle", 8'h00, 8'h40, 16'h0000);

        // Hand-worked cases (R2, R5, R1)
        drive(1, 'hF2, 'h68, 'h1234, 8'h00);
        check("R2 F2-68", 8'h8A, 8'h82 | 8'h10, 16'h1234);
        drive(4, 'h8A, 'h00, 'h1234, 8'h82);
        check("R5 inv 8A", 8'h75, 8'h92, 16'h1234);
        drive(0, 'h75, 'hA2, 'h1234, 8'h92);
        check("R1 75+A2", 8'h17, 8'h01, 16'h1234);

        // Exhaustive 8-bit sweep
        for (int op = 0; op < 6; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    logic [7:0] fin;
                    fin = ((a ^ b) & 1) ? 8'hFF : 8'h00;
                    drive(op, a, b, (a * 256 + b) ^ 16'h5A5A, fin);
                    model8(op, a, b, fin, er, ef);
                    check(tag_of(op), er, ef, pair_in);
                end
            end
        end

        // Pair operations, strided sweep plus wrap points (R6, R10)
        for (int op = 6; op < 8; op++) begin
            for (int p = 0; p < 65536; p += 251) begin
                logic [7:0] fin;
                logic [15:0] ep;
                fin = p[7:0] ^ 8'hC3;
                drive(op, p % 256, 'h3C, p, fin);
                ep = (op == 6) ? 16'(p + 1) : 16'(p - 1);
                check(tag_of(op), acc_in, fin, ep);
            end
        end
        drive(6, 'h11, 0, 'hFFFF, 8'hFF);
        check("R6 inc wrap", 8'h11, 8'hFF, 16'h0000);
        drive(7, 'h22, 0, 'h0000, 8'h00);
        check("R6 dec wrap", 8'h22, 8'h00, 16'hFFFF);
        drive(7, 'h33, 0, 'h8000, 8'hA5);
        check("R10 dec 8000", 8'h33, 8'hA5, 16'h7FFF);

        // Boundary cases called out in R3 and R4
        drive(2, 0, 'h7F, 0, 8'h01);
        check("R3 inc 7F", 8'h80, 8'h95, 16'h0000);
        drive(3, 0, 'h80, 0, 8'h00);
        check("R3 dec 80", 8'h7F, 8'h16, 16'h0000);
        drive(5, 'h80, 0, 0, 8'h00);
        check("R4 neg 80", 8'h80, 8'h87, 16'h0000);
        drive(5, 'h00, 0, 0, 8'h01);
        check("R4 neg 00", 8'h00, 8'h42, 16'h0000);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule